// File: doc/BRIEF.md
# Self-Modifying Code Hazard Detector

This block guards an in-order instruction pipeline against stores that overwrite instruction bytes that have already been fetched. Every pipeline stage presents a valid bit, the fetch address of the instruction it holds, and that instruction's length in bytes. When the write-back stage issues a store, the block compares the store address with the bytes held in all occupied stages. On a hit it picks the oldest instruction whose bytes were written. It then flushes that stage and every younger stage, and redirects fetch to that instruction's own address so the changed bytes are read again.

Stage index 0 is the youngest stage, next to fetch. Index `NUM_STAGES-1` is the oldest, next to write-back. A small state machine has two states. `SMC_WATCH` compares stores against the stages. `SMC_REDIRECT` drives the flush mask and the redirect for exactly one cycle. The transition *hit* (`SMC_WATCH` to `SMC_REDIRECT`) is taken on a strobed store that matches. The transition *done* (`SMC_REDIRECT` to `SMC_WATCH`) is always taken on the following edge. With no matching store the machine stays in `SMC_WATCH` (transition *idle*).

The parameter `WORD_MODE` chooses how addresses are compared. With `WORD_MODE=0`, each byte is compared exactly, using one comparator per byte slot per stage. With `WORD_MODE=1`, only the aligned 4-byte word indices are compared. This costs two comparators per stage and accepts false hits, but it never misses a real overwrite. `MAX_LEN` must not exceed 4.

Top module: `smc_hazard_detector`

## Requirements
- R1: While reset (`rst_n` low) is held and in the cycle after it is released, `flush_o` is all zero, `redir_o` is low and `redir_pc_o` is zero.
- R2: With `WORD_MODE=0`, a stage matches when it is valid and the store address equals its address plus k, modulo 2^ADDR_W, for some k below its length code. Length codes 1..3 mean 1..3 bytes, and code 0 means no bytes, so such a stage never matches.
- R3: With `WORD_MODE=1`, a stage matches when it is valid and the store address shifted right by 2 equals, for some k below its length, (address + k) shifted right by 2. Every store that is a hit under R2 is therefore also a hit in this mode.
- R4: A stage whose valid bit is clear never matches. A cycle with `st_we` low never causes a flush or a redirect.
- R5: When one or more stages match, the selected stage is the matching stage with the highest index. In the flush mask, bits 0 up to and including that index are set and every other bit is clear.
- R6: `redir_pc_o` carries the address of the selected stage while `redir_o` is high, and is zero otherwise.
- R7: The flush mask and `redir_o` appear in the cycle after the clock edge that samples the matching store, and they last exactly one cycle.
- R8: A store presented in the cycle in which `redir_o` is high is ignored. It causes no flush and no redirect in the next cycle.
- R9: With no hit pending, `flush_o` is all zero and `redir_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stg_valid | input | NUM_STAGES | Per-stage occupancy, bit i for stage i (0 youngest) |
| stg_addr | input | NUM_STAGES*ADDR_W | Fetch address of each stage, stage i at bits [i*ADDR_W +: ADDR_W] |
| stg_len | input | NUM_STAGES*LEN_W | Byte length code of each stage, stage i at bits [i*LEN_W +: LEN_W] |
| st_we | input | 1 | Store strobe from write-back |
| st_addr | input | ADDR_W | Byte address of the store |
| flush_o | output | NUM_STAGES | Stages to replace with bubbles, bit i for stage i |
| redir_o | output | 1 | One-cycle fetch redirect pulse |
| redir_pc_o | output | ADDR_W | Address to restart fetch from |

## Verification
The bench builds two instances with the default sizes: seven stages, 16-bit addresses and up to three bytes per instruction. One uses `WORD_MODE=0` and the other `WORD_MODE=1`, and both receive the same stimulus. This lets each store be judged side by side. A store to the unused byte that shares a word with an instruction shows a hit in the word instance and no hit in the byte instance. A store at the last byte of an instruction shows a hit in both. The 16-bit address width lets an instruction wrap past 0xFFFF within a short run. Seven stages are enough to exercise multiple matches, where the oldest stage must win.

// File: rtl/smc_pkg.sv
package smc_pkg;

    typedef enum logic [0:0] {
        SMC_WATCH    = 1'b0,
        SMC_REDIRECT = 1'b1
    } smc_state_e;

    // Byte-address bits below the word index in the coarse compare mode
    localparam int WORD_SHIFT = 2;

endpackage

// File: rtl/smc_stage_match.sv
module smc_stage_match #(
    parameter int ADDR_W    = 16,
    parameter int MAX_LEN   = 3,
    parameter bit WORD_MODE = 1'b0,
    localparam int LEN_W    = $clog2(MAX_LEN + 1)
) (
    input  logic              valid,
    input  logic [ADDR_W-1:0] base,
    input  logic [LEN_W-1:0]  len,
    input  logic [ADDR_W-1:0] st_addr,
    output logic              hit
);
    import smc_pkg::*;

    localparam int WIDX_W = ADDR_W - WORD_SHIFT;

    generate
        if (WORD_MODE == 1'b0) begin : g_byte
            logic [MAX_LEN-1:0] slot_hit;
            for (genvar b = 0; b < MAX_LEN; b++) begin : g_slot
                assign slot_hit[b] = (LEN_W'(b) < len) &&
                                     ((base + ADDR_W'(b)) == st_addr);
            end
            assign hit = valid && (|slot_hit);
        end else begin : g_word
            logic [ADDR_W-1:0] last_byte;
            logic [WIDX_W-1:0] first_w, last_w, st_w;
            assign last_byte = base + ADDR_W'(len) - ADDR_W'(1);
            assign first_w   = base[ADDR_W-1:WORD_SHIFT];
            assign last_w    = last_byte[ADDR_W-1:WORD_SHIFT];
            assign st_w      = st_addr[ADDR_W-1:WORD_SHIFT];
            assign hit = valid && (len != '0) &&
                         ((st_w == first_w) || (st_w == last_w));
        end
    endgenerate

endmodule

// File: rtl/smc_oldest_pick.sv
module smc_oldest_pick #(
    parameter int NUM_STAGES = 7,
    parameter int ADDR_W     = 16,
    localparam int IDX_W     = $clog2(NUM_STAGES)
) (
    input  logic [NUM_STAGES-1:0]        hits,
    input  logic [NUM_STAGES*ADDR_W-1:0] addr_flat,
    output logic                         any_hit,
    output logic [NUM_STAGES-1:0]        mask,
    output logic [ADDR_W-1:0]            pc
);
    logic [IDX_W-1:0] sel;

    // Highest index wins: scan upward so the last match stays
    always_comb begin
        sel     = '0;
        any_hit = 1'b0;
        for (int i = 0; i < NUM_STAGES; i++) begin
            if (hits[i]) begin
                sel     = IDX_W'(i);
                any_hit = 1'b1;
            end
        end
    end

    always_comb begin
        for (int j = 0; j < NUM_STAGES; j++) begin
            mask[j] = any_hit && (IDX_W'(j) <= sel);
        end
    end

    assign pc = addr_flat[sel*ADDR_W +: ADDR_W];

endmodule

// File: rtl/smc_hazard_detector.sv
module smc_hazard_detector #(
    parameter int NUM_STAGES = 7,
    parameter int ADDR_W     = 16,
    parameter int MAX_LEN    = 3,
    parameter bit WORD_MODE  = 1'b0,
    localparam int LEN_W     = $clog2(MAX_LEN + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_STAGES-1:0]        stg_valid,
    input  logic [NUM_STAGES*ADDR_W-1:0] stg_addr,
    input  logic [NUM_STAGES*LEN_W-1:0]  stg_len,
    input  logic                         st_we,
    input  logic [ADDR_W-1:0]            st_addr,
    output logic [NUM_STAGES-1:0]        flush_o,
    output logic                         redir_o,
    output logic [ADDR_W-1:0]            redir_pc_o
);
    import smc_pkg::*;

    logic [NUM_STAGES-1:0] stage_hit;
    logic                  any_hit;
    logic [NUM_STAGES-1:0] pick_mask;
    logic [ADDR_W-1:0]     pick_pc;

    smc_state_e            state_q, state_d;
    logic [NUM_STAGES-1:0] mask_q;
    logic [ADDR_W-1:0]     pc_q;
    logic                  take_hit;

    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
        smc_stage_match #(
            .ADDR_W   (ADDR_W),
            .MAX_LEN  (MAX_LEN),
            .WORD_MODE(WORD_MODE)
        ) u_match (
            .valid  (stg_valid[s]),
            .base   (stg_addr[s*ADDR_W +: ADDR_W]),
            .len    (stg_len[s*LEN_W +: LEN_W]),
            .st_addr(st_addr),
            .hit    (stage_hit[s])
        );
    end

    smc_oldest_pick #(
        .NUM_STAGES(NUM_STAGES),
        .ADDR_W    (ADDR_W)
    ) u_pick (
        .hits     (stage_hit),
        .addr_flat(stg_addr),
        .any_hit  (any_hit),
        .mask     (pick_mask),
        .pc       (pick_pc)
    );

    // Next state: hit / done / idle transitions
    always_comb begin
        state_d  = state_q;
        take_hit = 1'b0;
        unique case (state_q)
            SMC_WATCH: begin
                if (st_we && any_hit) begin
                    state_d  = SMC_REDIRECT;
                    take_hit = 1'b1;
                end
            end
            SMC_REDIRECT: state_d = SMC_WATCH;
            default:      state_d = SMC_WATCH;
        endcase
    end

    // State register and captured redirect target
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SMC_WATCH;
            mask_q  <= '0;
            pc_q    <= '0;
        end else begin
            state_q <= state_d;
            if (take_hit) begin
                mask_q <= pick_mask;
                pc_q   <= pick_pc;
            end
        end
    end

    // Outputs decoded from the state
    always_comb begin
        flush_o    = '0;
        redir_o    = 1'b0;
        redir_pc_o = '0;
        unique case (state_q)
            SMC_WATCH: ;
            SMC_REDIRECT: begin
                flush_o    = mask_q;
                redir_o    = 1'b1;
                redir_pc_o = pc_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/smc_hazard_checker.sv
module smc_hazard_checker #(
    parameter int NUM_STAGES = 7,
    parameter int ADDR_W     = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  st_we,
    input logic [NUM_STAGES-1:0] flush_o,
    input logic                  redir_o,
    input logic [ADDR_W-1:0]     redir_pc_o
);
    // R7
    redir_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_o |=> !redir_o);

    // R4
    no_store_no_redir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_we |=> !redir_o);

    // R5
    flush_youngest_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_o |-> flush_o[0]);

    // R5
    flush_contiguous_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_o |-> ((flush_o & (flush_o + NUM_STAGES'(1))) == '0));

    // R9
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !redir_o |-> (flush_o == '0));

    // R6
    pc_zero_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !redir_o |-> (redir_pc_o == '0));

endmodule

bind smc_hazard_detector smc_hazard_checker #(
    .NUM_STAGES(NUM_STAGES),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_we     (st_we),
    .flush_o   (flush_o),
    .redir_o   (redir_o),
    .redir_pc_o(redir_pc_o)
);

// File: tb/tb_smc_hazard_detector.sv
module tb_smc_hazard_detector;
    localparam int NS = 7;
    localparam int AW = 16;
    localparam int ML = 3;
    localparam int LW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NS-1:0]    stg_valid = '0;
    logic [NS*AW-1:0] stg_addr = '0;
    logic [NS*LW-1:0] stg_len = '0;
    logic             st_we = 1'b0;
    logic [AW-1:0]    st_addr = '0;

    logic [NS-1:0] flush_b, flush_w;
    logic          redir_b, redir_w;
    logic [AW-1:0] pc_b, pc_w;

    always #5 clk = ~clk;

    smc_hazard_detector #(.NUM_STAGES(NS), .ADDR_W(AW), .MAX_LEN(ML), .WORD_MODE(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .stg_valid(stg_valid), .stg_addr(stg_addr),
        .stg_len(stg_len), .st_we(st_we), .st_addr(st_addr),
        .flush_o(flush_b), .redir_o(redir_b), .redir_pc_o(pc_b));

    smc_hazard_detector #(.NUM_STAGES(NS), .ADDR_W(AW), .MAX_LEN(ML), .WORD_MODE(1'b1)) dut_word (
        .clk(clk), .rst_n(rst_n), .stg_valid(stg_valid), .stg_addr(stg_addr),
        .stg_len(stg_len), .st_we(st_we), .st_addr(st_addr),
        .flush_o(flush_w), .redir_o(redir_w), .redir_pc_o(pc_w));

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    int v[NS];
    int a[NS];
    int l[NS];
    int we_i;
    int sa_i;

    int busy[2];
    int emask[2];
    int epc[2];

    function automatic int oldest(int mode);
        int k;
        k = -1;
        for (int i = 0; i < NS; i++) begin
            for (int b = 0; b < l[i]; b++) begin
                int byte_a;
                byte_a = (a[i] + b) & 32'hFFFF;
                if (v[i] != 0) begin
                    if (mode == 0 && byte_a == sa_i) k = i;
                    if (mode == 1 && (byte_a >> 2) == (sa_i >> 2)) k = i;
                end
            end
        end
        return k;
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic clear_stages();
        for (int i = 0; i < NS; i++) begin
            v[i] = 0; a[i] = 0; l[i] = 1;
        end
        we_i = 0; sa_i = 0;
    endtask

    task automatic drive();
        for (int i = 0; i < NS; i++) begin
            stg_valid[i] = (v[i] != 0);
            stg_addr[i*AW +: AW] = AW'(a[i]);
            stg_len[i*LW +: LW] = LW'(l[i]);
        end
        st_we = (we_i != 0);
        st_addr = AW'(sa_i);
    endtask

    // One clock: drive, predict, wait past the edge, compare both instances
    task automatic step(string tag);
        int nb[2];
        int nm[2];
        int np[2];
        drive();
        for (int m = 0; m < 2; m++) begin
            int k;
            k = oldest(m);
            if (busy[m] == 0 && we_i != 0 && k >= 0) begin
                nb[m] = 1; nm[m] = (1 << (k + 1)) - 1; np[m] = a[k];
            end else begin
                nb[m] = 0; nm[m] = 0; np[m] = 0;
            end
        end
        @(negedge clk);
        for (int m = 0; m < 2; m++) begin
            busy[m] = nb[m]; emask[m] = nm[m]; epc[m] = np[m];
        end
        // R5 mask, R7 pulse timing, R6 redirect address
        check(tag, "byte flush (R5)", int'(flush_b), emask[0]);
        check(tag, "byte redirect (R7)", int'(redir_b), busy[0]);
        check(tag, "byte pc (R6)", int'(pc_b), epc[0]);
        check(tag, "word flush (R5)", int'(flush_w), emask[1]);
        check(tag, "word redirect (R7)", int'(redir_w), busy[1]);
        check(tag, "word pc (R6)", int'(pc_w), epc[1]);
    endtask

    initial begin
        clear_stages();
        busy[0] = 0; busy[1] = 0;
        repeat (2) @(negedge clk);
        // R1: outputs quiet during reset, even with a matching store presented
        v[2] = 1; a[2] = 16'h0040; l[2] = 2; we_i = 1; sa_i = 16'h0041;
        drive();
        @(negedge clk);
        check("R1", "flush in reset", int'(flush_b | flush_w), 0);
        check("R1", "redirect in reset", int'(redir_b | redir_w), 0);
        check("R1", "pc in reset", int'(pc_b | pc_w), 0);
        clear_stages();
        drive();
        rst_n = 1'b1;
        step("R1");

        // R2: byte hit inside a 3-byte instruction in stage 3
        clear_stages();
        v[3] = 1; a[3] = 16'h0100; l[3] = 3; we_i = 1; sa_i = 16'h0102;
        step("R2"); clear_stages(); step("R7");
        // R3: byte just past the end, same word: word mode only
        v[3] = 1; a[3] = 16'h0100; l[3] = 3; we_i = 1; sa_i = 16'h0103;
        step("R3"); clear_stages(); step("R3");
        check("R3", "byte instance ignored neighbour", int'(redir_b), 0);
        // R2: address wrap past the top of memory
        v[5] = 1; a[5] = 16'hFFFF; l[5] = 3; we_i = 1; sa_i = 16'h0001;
        step("R2"); clear_stages(); step("R2");
        // R2: length code 0 holds no bytes
        v[4] = 1; a[4] = 16'h0300; l[4] = 0; we_i = 1; sa_i = 16'h0300;
        step("R2"); clear_stages(); step("R2");
        // R4: invalid stage and low strobe
        v[2] = 0; a[2] = 16'h0500; l[2] = 3; we_i = 1; sa_i = 16'h0501;
        step("R4");
        v[2] = 1; we_i = 0;
        step("R4");
        clear_stages(); step("R4");
        check("R4", "no redirect after ignored stores", int'(redir_b | redir_w), 0);
        // R5: several matches, oldest wins
        v[1] = 1; a[1] = 16'h0700; l[1] = 1;
        v[4] = 1; a[4] = 16'h06FF; l[4] = 2;
        v[6] = 1; a[6] = 16'h06FE; l[6] = 3;
        we_i = 1; sa_i = 16'h0700;
        step("R5");
        // R8: the same store again during the redirect cycle is dropped
        step("R8");
        clear_stages(); step("R8");
        check("R8", "redirect after dropped store", int'(redir_b | redir_w), 0);
        // R9: oldest stage alone flushes the whole pipeline
        v[6] = 1; a[6] = 16'h0800; l[6] = 1; we_i = 1; sa_i = 16'h0800;
        step("R9"); clear_stages(); step("R9");

        // Random traffic in a narrow window so hits are frequent
        for (int c = 0; c < 3000; c++) begin
            for (int i = 0; i < NS; i++) begin
                v[i] = ($urandom_range(0, 3) != 0) ? 1 : 0;
                a[i] = (c % 500 == 7) ? int'($urandom_range(16'hFFFC, 16'hFFFF))
                                      : int'($urandom_range(16'h0200, 16'h021F));
                l[i] = int'($urandom_range(0, 3));
            end
            we_i = int'($urandom_range(0, 1));
            sa_i = (c % 500 == 7) ? int'($urandom_range(0, 3))
                                  : int'($urandom_range(16'h01FE, 16'h0222));
            step("R5");
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule